// File: doc/BRIEF.md
# Entropy Seed Sourcing Sequencer

This block sequences one generation round of a sensor-seeded cryptographic bit generator. After reset it rests in an idle state until a start switch is raised. It then waits for fresh sensor activity. A fresh set is one new microphone sample plus one completed accelerometer sweep. When the set is complete, the block asks an external mixing engine for a seed over a request/acknowledge handshake. If the set is still incomplete when a programmable cycle limit runs out, the block takes the current output of an external chaotic-map generator as the seed.

The chosen seed is presented to an external block-cipher engine with a one-cycle load strobe. The block then requests a programmable number of cipher output words. Each word goes to a recording port, but only when recording is enabled at the moment the word arrives. The sequencer never issues the same seed twice in a row: on a repeat it advances the chaotic map by one step and offers the new value. Lowering the start switch lets the block in flight finish and then returns the sequencer to idle. Raw sensor samples never reach the seed path. Only the mixer result or the chaotic value can become a seed.

Top module: `entropy_seed_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it, `mix_req`, `blk_req`, `rec_valid`, `seed_load` and `chaos_step` are low and `seed_src` is 0.
- R2: While `start_en` is low in the idle state, no mixer request, cipher request or seed load is issued.
- R3: Once at least one `mic_tick` and at least one `acc_tick` have been seen since the last seed load, the waiting state raises `mix_req`. The word on `mix_seed` in the acknowledge cycle becomes the seed (`seed_out` at the `seed_load` strobe) and `seed_src` becomes 0.
- R4: If fresh entropy is still incomplete after `tmo_limit`+1 waiting cycles, the seed is `chaos_val` with `seed_src` = 1 and no mixer request. The load strobe comes exactly `tmo_limit`+2 cycles after the final recording handshake of the previous seed, plus 2 cycles for each chaotic retry.
- R5: A cipher word accepted while `rec_en` is low is never presented on the recording port. A word accepted while `rec_en` is high appears on `rec_data` with `rec_valid` held until `rec_ready`.
- R6: A seed equal to the previously loaded seed is never loaded. In that case `chaos_step` pulses once, and the following `chaos_val` is loaded with `seed_src` = 1.
- R7: Between two seed loads with `start_en` held high, exactly `blk_per_seed` cipher words are accepted. A value of 0 acts as 1.
- R8: If `start_en` is low when a cipher word completes (accepted, and recorded when recording applies), the sequencer returns to idle. The same happens if `start_en` is low in the waiting state. Once idle, no further requests are issued.
- R9: `seed_src` changes only in the cycle after a `seed_load` strobe.
- R10: Sensor ticks count toward the next seed whenever they arrive after the last load, including during idle and while cipher words are produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_en | input | 1 | Start switch; generation runs only while high |
| rec_en | input | 1 | Recording enable, sampled when a cipher word is accepted |
| tmo_limit | input | TMO_W | Waiting-state cycle limit before chaotic fallback |
| blk_per_seed | input | CNT_W | Cipher words per seed (0 acts as 1) |
| mic_tick | input | 1 | Pulse: new microphone sample available |
| acc_tick | input | 1 | Pulse: accelerometer sweep finished |
| mix_req | output | 1 | Request to the seed-mixing engine |
| mix_ack | input | 1 | Mixer acknowledge; `mix_seed` valid |
| mix_seed | input | SEED_W | Mixed seed word |
| chaos_val | input | SEED_W | Current chaotic-map value |
| chaos_step | output | 1 | Pulse: advance the chaotic map |
| seed_out | output | SEED_W | Seed for the cipher engine |
| seed_load | output | 1 | One-cycle strobe: cipher takes `seed_out` |
| seed_src | output | 1 | 0 = sensor-mixed seed, 1 = chaotic fallback |
| blk_req | output | 1 | Request one cipher output word |
| blk_ack | input | 1 | Cipher acknowledge; `blk_data` valid |
| blk_data | input | BLK_W | Cipher output word |
| rec_valid | output | 1 | Recording port data valid |
| rec_ready | input | 1 | Recording port ready |
| rec_data | output | BLK_W | Word to record |

## Verification
Assertions cover the rules that can be stated one cycle at a time:
- reset returns the sequencer to idle;
- idle holds while the switch is low;
- a mixer request rises only after fresh entropy;
- waiting continues while the timer runs;
- a word accepted with recording off never reaches the recording port;
- the source flag is stable between loads;
- the sequencer is idle after a stopped block;
- the seed offered at each load differs from the previous one.

Only the bench's scenarios can show the remaining behaviour:
- the exact load cycle after a timeout, with and without chaotic retries;
- that the loaded value matches the mixer or chaotic word;
- the count of words per seed;
- ticks arriving during generation speeding up the next seed;
- exactly one more block completing after the switch drops.

// File: rtl/eseed_pkg.sv
package eseed_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_COLLECT = 3'd1,
        ST_MIX     = 3'd2,
        ST_SEED    = 3'd3,
        ST_GEN     = 3'd4,
        ST_REC     = 3'd5
    } seq_state_e;

endpackage

// File: rtl/eseed_fresh_track.sv
module eseed_fresh_track (
    input  logic clk,
    input  logic rst,
    input  logic mic_tick,
    input  logic acc_tick,
    input  logic clr,
    output logic fresh
);
    logic mic_seen_d, mic_seen_q;
    logic acc_seen_d, acc_seen_q;

    // A tick in the clearing cycle belongs to the next seed.
    always_comb begin
        mic_seen_d = (mic_seen_q & ~clr) | mic_tick;
        acc_seen_d = (acc_seen_q & ~clr) | acc_tick;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mic_seen_q <= 1'b0;
            acc_seen_q <= 1'b0;
        end else begin
            mic_seen_q <= mic_seen_d;
            acc_seen_q <= acc_seen_d;
        end
    end

    assign fresh = mic_seen_q & acc_seen_q;

    // R10: a tick is never lost unless a clear coincides with no tick
    assert_tick_kept_R10: assert property (@(posedge clk) disable iff (rst)
        (mic_tick && acc_tick) |=> fresh);
endmodule

// File: rtl/eseed_timer.sv
module eseed_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    assign expired = (cnt_q >= limit);

    always_comb begin
        cnt_d = cnt_q;
        if (restart) begin
            cnt_d = '0;
        end else if (run && !expired) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R4: the count never passes the limit while waiting
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
        (run && !restart && expired) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/eseed_repeat_guard.sv
module eseed_repeat_guard #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         commit,
    input  logic [W-1:0] cand,
    output logic         dup
);
    logic [W-1:0] prev_d, prev_q;
    logic         have_d, have_q;

    assign dup = have_q && (cand == prev_q);

    always_comb begin
        prev_d = prev_q;
        have_d = have_q;
        if (commit) begin
            prev_d = cand;
            have_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            have_q <= 1'b0;
        end else begin
            prev_q <= prev_d;
            have_q <= have_d;
        end
    end

    // R6: the sequencer never commits a seed equal to the last one
    assert_no_repeat_R6: assert property (@(posedge clk) disable iff (rst)
        (commit && have_q) |-> (cand != prev_q));
endmodule

// File: rtl/entropy_seed_seq.sv
module entropy_seed_seq
    import eseed_pkg::*;
#(
    parameter int SEED_W = 32,
    parameter int BLK_W  = 32,
    parameter int TMO_W  = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_en,
    input  logic              rec_en,
    input  logic [TMO_W-1:0]  tmo_limit,
    input  logic [CNT_W-1:0]  blk_per_seed,
    input  logic              mic_tick,
    input  logic              acc_tick,
    output logic              mix_req,
    input  logic              mix_ack,
    input  logic [SEED_W-1:0] mix_seed,
    input  logic [SEED_W-1:0] chaos_val,
    output logic              chaos_step,
    output logic [SEED_W-1:0] seed_out,
    output logic              seed_load,
    output logic              seed_src,
    output logic              blk_req,
    input  logic              blk_ack,
    input  logic [BLK_W-1:0]  blk_data,
    output logic              rec_valid,
    input  logic              rec_ready,
    output logic [BLK_W-1:0]  rec_data
);
    localparam int NB_W = CNT_W + 1;

    typedef struct packed {
        seq_state_e        st;
        logic [SEED_W-1:0] cand;
        logic              cand_chaos;
        logic              pend;
        logic              src;
        logic [BLK_W-1:0]  word;
        logic [CNT_W-1:0]  nblk;
    } seq_regs_t;

    seq_regs_t q, d;

    logic fresh, expired, dup;
    logic tmr_restart, tmr_run, fresh_clr, commit;
    logic [NB_W-1:0] nblk_inc;
    logic            last_blk;

    eseed_fresh_track u_fresh (
        .clk      (clk),
        .rst      (rst),
        .mic_tick (mic_tick),
        .acc_tick (acc_tick),
        .clr      (fresh_clr),
        .fresh    (fresh)
    );

    eseed_timer #(.W(TMO_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (tmr_restart),
        .run     (tmr_run),
        .limit   (tmo_limit),
        .expired (expired)
    );

    eseed_repeat_guard #(.W(SEED_W)) u_guard (
        .clk    (clk),
        .rst    (rst),
        .commit (commit),
        .cand   (q.cand),
        .dup    (dup)
    );

    assign nblk_inc = {1'b0, q.nblk} + 1'b1;
    assign last_blk = (nblk_inc >= {1'b0, blk_per_seed});

    always_comb begin
        d           = q;
        seed_load   = 1'b0;
        chaos_step  = 1'b0;
        tmr_restart = 1'b0;
        tmr_run     = 1'b0;
        fresh_clr   = 1'b0;
        commit      = 1'b0;

        // Shared tail of a finished cipher word.
        unique case (q.st)
            ST_IDLE: begin
                tmr_restart = 1'b1;
                if (start_en) begin
                    d.st = ST_COLLECT;
                end
            end
            ST_COLLECT: begin
                tmr_run = 1'b1;
                if (!start_en) begin
                    d.st = ST_IDLE;
                end else if (fresh) begin
                    d.st = ST_MIX;
                end else if (expired) begin
                    d.cand       = chaos_val;
                    d.cand_chaos = 1'b1;
                    d.pend       = 1'b0;
                    d.st         = ST_SEED;
                end
            end
            ST_MIX: begin
                if (mix_ack) begin
                    d.cand       = mix_seed;
                    d.cand_chaos = 1'b0;
                    d.pend       = 1'b0;
                    d.st         = ST_SEED;
                end
            end
            ST_SEED: begin
                if (q.pend) begin
                    d.cand       = chaos_val;
                    d.cand_chaos = 1'b1;
                    d.pend       = 1'b0;
                end else if (dup) begin
                    chaos_step = 1'b1;
                    d.pend     = 1'b1;
                end else begin
                    seed_load = 1'b1;
                    commit    = 1'b1;
                    fresh_clr = 1'b1;
                    d.src     = q.cand_chaos;
                    d.nblk    = '0;
                    d.st      = ST_GEN;
                end
            end
            ST_GEN: begin
                if (blk_ack) begin
                    d.word = blk_data;
                    if (rec_en) begin
                        d.st = ST_REC;
                    end else begin
                        d.nblk = nblk_inc[CNT_W-1:0];
                        if (!start_en) begin
                            d.st = ST_IDLE;
                        end else if (last_blk) begin
                            d.st        = ST_COLLECT;
                            tmr_restart = 1'b1;
                        end else begin
                            d.st = ST_GEN;
                        end
                    end
                end
            end
            ST_REC: begin
                if (rec_ready) begin
                    d.nblk = nblk_inc[CNT_W-1:0];
                    if (!start_en) begin
                        d.st = ST_IDLE;
                    end else if (last_blk) begin
                        d.st        = ST_COLLECT;
                        tmr_restart = 1'b1;
                    end else begin
                        d.st = ST_GEN;
                    end
                end
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '{st: ST_IDLE, cand: '0, cand_chaos: 1'b0, pend: 1'b0,
                   src: 1'b0, word: '0, nblk: '0};
        end else begin
            q <= d;
        end
    end

    assign mix_req   = (q.st == ST_MIX);
    assign blk_req   = (q.st == ST_GEN);
    assign rec_valid = (q.st == ST_REC);
    assign rec_data  = q.word;
    assign seed_out  = q.cand;
    assign seed_src  = q.src;

    // R1: reset always lands in idle
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (q.st == ST_IDLE));

    // R2: idle holds while the switch is low
    assert_start_gate_R2: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_IDLE && !start_en) |=> !mix_req && !blk_req && !seed_load);

    // R3: the mixer is asked only after fresh entropy was seen
    assert_mix_fresh_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(mix_req) |-> $past(fresh));

    // R4: waiting continues until the limit while entropy is incomplete
    assert_tmo_wait_R4: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_COLLECT && start_en && !fresh && !expired) |=> (q.st == ST_COLLECT));

    // R5: a word accepted with recording off never reaches the port
    assert_rec_gate_R5: assert property (@(posedge clk) disable iff (rst)
        (blk_req && blk_ack && !rec_en) |=> !rec_valid);

    // R8: a recorded word with the switch low ends in idle
    assert_stop_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && rec_ready && !start_en) |=> (q.st == ST_IDLE));

    // R9: the source flag moves only after a load strobe
    assert_src_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !seed_load |=> $stable(seed_src));
endmodule

// File: tb/tb_entropy_seed_seq.sv
module tb_entropy_seed_seq;
    localparam int CLK_PERIOD = 10;
    localparam int SW = 32;
    localparam int BW = 32;

    logic          clk, rst, start_en, rec_en;
    logic [15:0]   tmo_limit;
    logic [7:0]    blk_per_seed;
    logic          mic_tick, acc_tick;
    logic          mix_req, mix_ack;
    logic [SW-1:0] mix_seed, chaos_val, seed_out;
    logic          chaos_step, seed_load, seed_src;
    logic          blk_req, blk_ack;
    logic [BW-1:0] blk_data, rec_data;
    logic          rec_valid, rec_ready;

    entropy_seed_seq dut (
        .clk(clk), .rst(rst), .start_en(start_en), .rec_en(rec_en),
        .tmo_limit(tmo_limit), .blk_per_seed(blk_per_seed),
        .mic_tick(mic_tick), .acc_tick(acc_tick),
        .mix_req(mix_req), .mix_ack(mix_ack), .mix_seed(mix_seed),
        .chaos_val(chaos_val), .chaos_step(chaos_step),
        .seed_out(seed_out), .seed_load(seed_load), .seed_src(seed_src),
        .blk_req(blk_req), .blk_ack(blk_ack), .blk_data(blk_data),
        .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_data(rec_data)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int bad   = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [SW-1:0] chaos_next(input logic [SW-1:0] x);
        return x * 32'd1664525 + 32'd1013904223;
    endfunction

    // observer / responder state
    int cyc = 0, loads = 0, mix_hs = 0, blk_cnt = 0, blk_since_load = 0;
    int rec_cnt = 0, rec_time = 0, steps_total = 0, steps_since_load = 0, load_time = 0;
    bit have_seed = 0, mix_pend = 0, rec_since_load = 0, src_chk_pend = 0;
    bit exp_src = 0, prev_load = 0, prev_src = 0, bps_valid = 0;
    bit tmo_chk = 0, force_dup = 0, rnd_ready = 0, via_mix;
    logic [SW-1:0] last_seed = '0, mix_given = '0, ex_seed;
    logic [BW-1:0] last_blk = '0;
    int exp_bps;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (src_chk_pend)
                check(seed_src == exp_src, exp_src ? "R4" : "R3", "seed_src after load",
                      seed_src, exp_src);
            else if (seed_src != prev_src && !prev_load)
                check(1'b0, "R9", "seed_src moved without load", seed_src, prev_src);
            src_chk_pend = 0;
            prev_src  = seed_src;
            prev_load = seed_load;
            if (!start_en) bps_valid = 0;

            if (seed_load) begin
                via_mix = mix_pend && !(have_seed && mix_given == last_seed);
                ex_seed = via_mix ? mix_given : chaos_val;
                check(seed_out == ex_seed, via_mix ? "R3" : (mix_pend ? "R6" : "R4"),
                      "loaded seed", seed_out, ex_seed);
                if (have_seed)
                    check(seed_out != last_seed, "R6", "seed repeated", seed_out, last_seed);
                exp_bps = (blk_per_seed == 0) ? 1 : int'(blk_per_seed);
                if (bps_valid)
                    check(blk_since_load == exp_bps, "R7", "words per seed",
                          blk_since_load, exp_bps);
                if (tmo_chk && !mix_pend && rec_since_load)
                    check(cyc - rec_time == int'(tmo_limit) + 2 + 2 * steps_since_load,
                          "R4", "timeout load cycle", cyc - rec_time,
                          int'(tmo_limit) + 2 + 2 * steps_since_load);
                exp_src = !via_mix;
                src_chk_pend = 1;
                last_seed = seed_out;
                have_seed = 1;
                mix_pend = 0;
                loads++;
                load_time = cyc;
                blk_since_load = 0;
                steps_since_load = 0;
                rec_since_load = 0;
                bps_valid = start_en;
            end

            rec_ready = rnd_ready ? 1'($urandom % 2) : 1'b1;
            if (rec_valid && rec_ready) begin
                check(rec_data == last_blk, "R5", "recorded word", rec_data, last_blk);
                rec_cnt++;
                rec_time = cyc;
                rec_since_load = 1;
            end

            if (mix_req && !mix_ack) begin
                mix_ack  = 1'b1;
                mix_seed = (force_dup && have_seed) ? last_seed : $urandom;
                mix_pend = 1;
                mix_given = mix_seed;
                mix_hs++;
            end else begin
                mix_ack = 1'b0;
            end

            if (blk_req && !blk_ack) begin
                blk_ack  = 1'b1;
                blk_data = $urandom;
                last_blk = blk_data;
                blk_cnt++;
                blk_since_load++;
            end else begin
                blk_ack = 1'b0;
            end

            if (chaos_step) begin
                chaos_val = chaos_next(chaos_val);
                steps_total++;
                steps_since_load++;
            end
        end
    end

    task automatic step_cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_both();
        mic_tick = 1'b1;
        acc_tick = 1'b1;
        step_cycles(1);
        mic_tick = 1'b0;
        acc_tick = 1'b0;
    endtask

    task automatic wait_loads(input int n);
        while (loads < n) step_cycles(1);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        finish_run();
    end

    initial begin
        int s0, b0, r0, l0, m0, t4;
        void'($urandom(32'd2024));
        rst = 1'b1; start_en = 1'b0; rec_en = 1'b1;
        tmo_limit = 16'd20; blk_per_seed = 8'd1;
        mic_tick = 1'b0; acc_tick = 1'b0;
        mix_ack = 1'b0; mix_seed = '0; chaos_val = 32'h1234_5678;
        blk_ack = 1'b0; blk_data = '0; rec_ready = 1'b1;

        // R1: reset state
        step_cycles(3);
        check(!mix_req && !blk_req && !rec_valid, "R1", "requests in reset",
              {mix_req, blk_req, rec_valid}, 0);
        check(!seed_load && !chaos_step && !seed_src, "R1", "strobes in reset",
              {seed_load, chaos_step, seed_src}, 0);
        rst = 1'b0;
        step_cycles(1);
        check(!mix_req && !blk_req && !seed_load, "R1", "first cycle after reset",
              {mix_req, blk_req, seed_load}, 0);

        // R2: switch low keeps everything quiet
        step_cycles(20);
        check(loads == 0 && blk_cnt == 0 && mix_hs == 0, "R2", "activity while stopped",
              loads + blk_cnt + mix_hs, 0);

        // R4 and R6: no ticks, repeated chaotic fallbacks
        tmo_chk = 1;
        start_en = 1'b1;
        wait_loads(3);
        tmo_chk = 0;
        check(mix_hs == 0, "R4", "mixer used without entropy", mix_hs, 0);
        check(steps_total == 2, "R6", "chaotic retries", steps_total, 2);
        // R8: stop, block in flight completes, then idle
        start_en = 1'b0;
        step_cycles(40);
        check(loads == 3 && !blk_req && !mix_req, "R8", "idle after stop",
              loads, 3);

        // R3, R7, R10: mixer path, ticks during generation
        pulse_both();
        tmo_limit = 16'd500;
        blk_per_seed = 8'd3;
        start_en = 1'b1;
        wait_loads(4);
        check(mix_hs == 1, "R3", "mixer handshakes", mix_hs, 1);
        l0 = load_time;
        step_cycles(3);
        pulse_both();
        wait_loads(5);
        check(mix_hs == 2, "R10", "ticks during generation used", mix_hs, 2);
        check(load_time - l0 < 100, "R10", "reseed delay", load_time - l0, 100);

        // R6: mixer returns the previous seed
        force_dup = 1;
        s0 = steps_total;
        pulse_both();
        wait_loads(6);
        force_dup = 0;
        check(steps_total == s0 + 1, "R6", "step on mixer repeat", steps_total, s0 + 1);
        step_cycles(1);
        check(seed_src == 1'b1, "R6", "source after repeat", seed_src, 1);

        // R5: recording disabled
        rec_en = 1'b0;
        pulse_both();
        wait_loads(7);
        r0 = rec_cnt;
        b0 = blk_cnt;
        pulse_both();
        wait_loads(8);
        check(rec_cnt == r0, "R5", "records while disabled", rec_cnt, r0);
        check(blk_cnt == b0 + 3, "R7", "words with recording off", blk_cnt - b0, 3);

        // R8: stop in the middle of generation
        while (!blk_req) step_cycles(1);
        start_en = 1'b0;
        b0 = blk_cnt;
        l0 = loads;
        m0 = mix_hs;
        step_cycles(40);
        check(blk_cnt == b0 + 1, "R8", "words after stop", blk_cnt - b0, 1);
        check(!blk_req && !mix_req && loads == l0 && mix_hs == m0, "R8", "quiet after stop",
              loads, l0);

        // random rounds
        rnd_ready = 1;
        for (int r = 0; r < 30; r++) begin
            blk_per_seed = 8'(1 + $urandom % 4);
            tmo_limit = 16'($urandom % 40);
            rec_en = 1'($urandom % 2);
            t4 = loads;
            start_en = 1'b1;
            for (int c = 0; c < 300; c++) begin
                mic_tick = ($urandom % 25) == 0;
                acc_tick = ($urandom % 25) == 0;
                step_cycles(1);
            end
            mic_tick = 1'b0;
            acc_tick = 1'b0;
            start_en = 1'b0;
            step_cycles(60);
            check(loads > t4, "R3", "progress in random round", loads - t4, 1);
            check(!blk_req && !mix_req && !rec_valid, "R8", "idle after random round",
                  {blk_req, mix_req, rec_valid}, 0);
        end

        finish_run();
    end
endmodule